// File: doc/BRIEF.md
# Port change interrupt unit

This unit watches a bank of general-purpose input pins, grouped into ports of equal width, and pulls an active-low, open-drain interrupt line whenever a watched pin settles at a new level. Each pin is passed through its own deglitch filter, so a level only counts once it has held steady for a programmable number of clock cycles. The default count corresponds to roughly 8 microseconds at a 125 MHz clock. Pin levels arrive already synchronized. The direction, mode and interrupt-mask bits come from a register file elsewhere in the chip.

Every port keeps a reference copy of its filtered levels. A port has a pending change when a watched pin's filtered level differs from that copy. The host clears a port's pending change by reading that port's input register. The register file signals the read with a one-cycle strobe for that port, and the strobe also refreshes the port's reference copy. The interrupt line stays low while any port has a pending change. A hardware reset or a software reset pulse clears all pending state and releases the line.

Top module: `pinchg_irq`

## Requirements
- R1: A pin is watched only when its mode bit is 1 (general-purpose), its direction bit is 1 (input) and its mask bit is 0. Any other combination of these three bits never raises the interrupt for that pin.
- R2: A low-to-high change and a high-to-low change on a watched pin both raise the interrupt.
- R3: A new raw level is accepted only after it has differed from the filtered level on FILT_CYC consecutive clock edges. After a raw change, irq_n stays high through FILT_CYC-1 edges and is low after FILT_CYC+1 edges.
- R4: A pin that returns to its previous level before FILT_CYC edges have passed raises no interrupt.
- R5: Port k covers pins k*PORT_W to k*PORT_W+PORT_W-1. Only rd_strobe[k] clears port k's pending change, so a strobe for another port leaves it pending.
- R6: irq_n stays low while any port has a pending change. It returns high only after every pending port has been read.
- R7: If a watched pin's filtered level changes on the same clock edge as its port's read strobe, that port stays pending after the read.
- R8: Asserting rst_n low, or pulsing soft_rst for one cycle, clears every pending change and releases irq_n. Pin levels present at either kind of reset are taken as the new reference and raise no interrupt.
- R9: irq_drive_low is 1 exactly when irq_n is 0, so the pad driver only ever pulls low or releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | One-cycle software reset pulse |
| pin_lvl | input | NUM_PORTS*PORT_W | Synchronized pin levels |
| pin_is_gpio | input | NUM_PORTS*PORT_W | 1 = general-purpose mode, 0 = LED mode |
| pin_is_input | input | NUM_PORTS*PORT_W | 1 = input, 0 = output |
| pin_irq_mask | input | NUM_PORTS*PORT_W | 1 = interrupt disabled for the pin |
| rd_strobe | input | NUM_PORTS | Per-port read of its input register |
| irq_n | output | 1 | Active-low interrupt |
| irq_drive_low | output | 1 | Open-drain pull-down enable |

## Verification
The bench builds the unit with two ports of eight pins and FILT_CYC set to 4. At that filter length, the edges just before and just after acceptance can be counted exactly. The short filter also makes a full sweep practical: every pin is toggled under all eight mode/direction/mask combinations, and the pin levels alternate so that both edge directions occur. The short window also makes it practical to land a filter acceptance on exactly the same edge as a read strobe, and to set up bounces one edge shorter and one edge longer than the window.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;
    // about 8 us at 125 MHz
    localparam int unsigned PINCHG_DEF_FILT  = 1000;
    localparam int unsigned PINCHG_DEF_PORTS = 2;
    localparam int unsigned PINCHG_DEF_WIDTH = 8;
endpackage

// File: rtl/pinchg_deglitch.sv
module pinchg_deglitch #(
    parameter int unsigned FILT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic raw,
    output logic filt,
    output logic flip
);
    localparam int unsigned CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } dg_st_t;

    dg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        flip = 1'b0;
        if (load) begin
            st_d.lvl = raw;
            st_d.cnt = '0;
        end else if (raw != st_q.lvl) begin
            if (st_q.cnt == LAST) begin
                st_d.lvl = raw;
                st_d.cnt = '0;
                flip     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt = st_q.lvl;
endmodule

// File: rtl/pinchg_port.sv
module pinchg_port #(
    parameter int unsigned PORT_W   = 8,
    parameter int unsigned FILT_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PORT_W-1:0] raw,
    input  logic [PORT_W-1:0] watch,
    input  logic              rd,
    output logic              pend
);
    typedef struct packed {
        logic [PORT_W-1:0] snap;
        logic              pend;
    } pt_st_t;

    pt_st_t            st_d, st_q;
    logic [PORT_W-1:0] filt;
    logic [PORT_W-1:0] flip;

    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
        pinchg_deglitch #(.FILT_CYC(FILT_CYC)) u_dg (
            .clk  (clk),
            .rst_n(rst_n),
            .load (load),
            .raw  (raw[b]),
            .filt (filt[b]),
            .flip (flip[b])
        );
    end

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.snap = raw;
            st_d.pend = 1'b0;
        end else if (rd) begin
            // reference takes the level before any acceptance on this edge
            st_d.snap = filt;
            st_d.pend = |(flip & watch);
        end else begin
            st_d.pend = st_q.pend | (|((filt ^ st_q.snap) & watch));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/pinchg_irq.sv
module pinchg_irq
    import pinchg_pkg::*;
#(
    parameter int unsigned NUM_PORTS = PINCHG_DEF_PORTS,
    parameter int unsigned PORT_W    = PINCHG_DEF_WIDTH,
    parameter int unsigned FILT_CYC  = PINCHG_DEF_FILT
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          soft_rst,
    input  logic [NUM_PORTS*PORT_W-1:0]   pin_lvl,
    input  logic [NUM_PORTS*PORT_W-1:0]   pin_is_gpio,
    input  logic [NUM_PORTS*PORT_W-1:0]   pin_is_input,
    input  logic [NUM_PORTS*PORT_W-1:0]   pin_irq_mask,
    input  logic [NUM_PORTS-1:0]          rd_strobe,
    output logic                          irq_n,
    output logic                          irq_drive_low
);
    localparam int unsigned NPINS = NUM_PORTS * PORT_W;

    typedef struct packed {
        logic ready;
    } top_st_t;

    top_st_t              st_d, st_q;
    logic                 load;
    logic [NPINS-1:0]     watch;
    logic [NUM_PORTS-1:0] pend_vec;

    always_comb begin
        st_d       = st_q;
        st_d.ready = !soft_rst;
        load       = !st_q.ready || soft_rst;
        watch      = pin_is_gpio & pin_is_input & ~pin_irq_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        pinchg_port #(.PORT_W(PORT_W), .FILT_CYC(FILT_CYC)) u_port (
            .clk  (clk),
            .rst_n(rst_n),
            .load (load),
            .raw  (pin_lvl[g*PORT_W +: PORT_W]),
            .watch(watch[g*PORT_W +: PORT_W]),
            .rd   (rd_strobe[g]),
            .pend (pend_vec[g])
        );
    end

    assign irq_drive_low = |pend_vec;
    assign irq_n         = ~irq_drive_low;
endmodule

// File: rtl/pinchg_irq_chk.sv
module pinchg_irq_chk #(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned NPINS     = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 soft_rst,
    input logic [NUM_PORTS-1:0] rd_strobe,
    input logic [NUM_PORTS-1:0] pend_vec,
    input logic [NPINS-1:0]     watch,
    input logic                 irq_n
);
    // R1
    watched_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(|watch));

    // R5
    port0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec[0] && !rd_strobe[0] && !soft_rst) |=> pend_vec[0]);

    // R5
    port1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec[NUM_PORTS-1] && !rd_strobe[NUM_PORTS-1] && !soft_rst) |=> pend_vec[NUM_PORTS-1]);

    // R8
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> irq_n);
endmodule

bind pinchg_irq pinchg_irq_chk #(.NUM_PORTS(NUM_PORTS), .NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .rd_strobe(rd_strobe),
    .pend_vec (pend_vec),
    .watch    (watch),
    .irq_n    (irq_n)
);

// File: tb/tb_pinchg_irq.sv
module tb_pinchg_irq;
    localparam int FILT = 4;
    localparam int PW   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [15:0] pin_lvl = 16'hA5C3;
    logic [15:0] pin_is_gpio = 16'hFFFF;
    logic [15:0] pin_is_input = 16'hFFFF;
    logic [15:0] pin_irq_mask = 16'h0000;
    logic [1:0]  rd_strobe = 2'b00;
    logic        irq_n;
    logic        irq_drive_low;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pinchg_irq #(.NUM_PORTS(2), .PORT_W(PW), .FILT_CYC(FILT)) dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pin_lvl(pin_lvl),
        .pin_is_gpio(pin_is_gpio), .pin_is_input(pin_is_input),
        .pin_irq_mask(pin_irq_mask), .rd_strobe(rd_strobe),
        .irq_n(irq_n), .irq_drive_low(irq_drive_low));

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] which);
        rd_strobe = which;
        step(1);
        rd_strobe = 2'b00;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step(3);
        // R8 reset state: levels present at reset are no change
        chk("R8 reset release", irq_n, 1'b1);
        chk("R9 reset drive", irq_drive_low, 1'b0);

        // R1/R2/R3/R5/R9 sweep: every pin, every mode/direction/mask combination
        for (int p = 0; p < 16; p++) begin
            for (int c = 0; c < 8; c++) begin
                logic exp;
                int   port;
                port = p / PW;
                exp  = (c[0] == 1) && (c[1] == 1) && (c[2] == 0);
                pin_is_gpio[p]  = c[0];
                pin_is_input[p] = c[1];
                pin_irq_mask[p] = c[2];
                pin_lvl[p]      = ~pin_lvl[p];
                step(FILT - 1);
                chk("R3 not before window", irq_n, 1'b1);
                step(2);
                chk(exp ? (pin_lvl[p] ? "R2 rising" : "R2 falling") : "R1 unwatched", irq_n, !exp);
                chk("R9 drive enable", irq_drive_low, !irq_n);
                if (exp) begin
                    rd(port == 0 ? 2'b10 : 2'b01);
                    chk("R5 other port read", irq_n, 1'b0);
                    rd(port == 0 ? 2'b01 : 2'b10);
                    chk("R5 own port read", irq_n, 1'b1);
                end
                rd(2'b11);
                step(1);
                pin_is_gpio[p]  = 1'b1;
                pin_is_input[p] = 1'b1;
                pin_irq_mask[p] = 1'b0;
                step(1);
            end
        end
        chk("R1 idle after sweep", irq_n, 1'b1);

        // R4 bounce one edge short of the window
        pin_lvl[3] = ~pin_lvl[3];
        step(FILT - 1);
        pin_lvl[3] = ~pin_lvl[3];
        step(FILT + 2);
        chk("R4 short bounce", irq_n, 1'b1);

        // R3 pulse of exactly the window is accepted
        pin_lvl[3] = ~pin_lvl[3];
        step(FILT);
        pin_lvl[3] = ~pin_lvl[3];
        step(FILT + 2);
        chk("R3 full-window pulse", irq_n, 1'b0);
        rd(2'b01);
        chk("R3 cleared", irq_n, 1'b1);

        // R6 both ports pending
        pin_lvl[1] = ~pin_lvl[1];
        pin_lvl[9] = ~pin_lvl[9];
        step(FILT + 2);
        rd(2'b01);
        chk("R6 port1 still pending", irq_n, 1'b0);
        rd(2'b10);
        chk("R6 all read", irq_n, 1'b1);

        // R7 acceptance on the same edge as the read
        pin_lvl[2] = ~pin_lvl[2];
        step(FILT + 2);
        pin_lvl[4] = ~pin_lvl[4];
        step(FILT - 1);
        rd(2'b01);
        chk("R7 same-edge change kept", irq_n, 1'b0);
        step(3);
        chk("R7 still pending", irq_n, 1'b0);
        rd(2'b01);
        chk("R7 second read clears", irq_n, 1'b1);

        // R8 software reset
        pin_lvl[12] = ~pin_lvl[12];
        step(FILT + 2);
        chk("R8 pending before soft reset", irq_n, 1'b0);
        pin_lvl[5] = ~pin_lvl[5];
        soft_rst = 1'b1;
        step(1);
        soft_rst = 1'b0;
        chk("R8 soft reset release", irq_n, 1'b1);
        step(FILT + 4);
        chk("R8 no change after soft reset", irq_n, 1'b1);

        // R8 hardware reset
        pin_lvl[13] = ~pin_lvl[13];
        step(FILT + 2);
        rst_n = 1'b0;
        step(1);
        chk("R8 hard reset release", irq_n, 1'b1);
        pin_lvl[0] = ~pin_lvl[0];
        rst_n = 1'b1;
        step(FILT + 4);
        chk("R8 no change after hard reset", irq_n, 1'b1);
        chk("R9 final drive", irq_drive_low, 1'b0);

        finish_run();
    end
endmodule